// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a single-clock RAM with one write port and one read port over a shared storage array. The two ports see the same bits with different aspect ratios, so data written as wide words can be read back as narrow words, or the reverse. The array holds 8192 bits when both ports use power-of-two widths. It holds 9216 bits when both ports use the parity-carrying widths of 9 or 18 bits. Port depths follow from the width: depth equals array bits divided by port width.

Narrow words are packed into wide words with the lowest narrow address in the least significant bits. A read is registered: the data appears one clock after the address is taken with read enable high, and it holds while read enable is low. A read that touches any bit being written in the same cycle returns the contents from before that write. A registered flag marks each read result that came from such a collision.

Width pairs are fixed by parameters. A pair that the storage cannot support stops elaboration.

Top module: `mwram_sdp`

## Requirements
- R1: Write depth is array bits / WR_WIDTH and read depth is array bits / RD_WIDTH. Every address of each port, including the last one, reaches distinct storage.
- R2: With width ratio k = wide/narrow, narrow address N*k+i maps to bits [(i+1)*w-1 : i*w] of wide word N, where w is the narrow width.
- R3: Legal pairs are write 16 with read 1, 2, 4, 8 or 16 (8192 bits), and any pair drawn from {9, 18} (9216 bits). Any other pair fails elaboration. A 9-bit write with an 18-bit read returns the full 18 bits.
- R4: A read with rd_en_i high at a clock edge drives the stored data on rd_data_o after that edge.
- R5: While rd_en_i is low, rd_data_o and rd_collide_o keep their values, whatever the write port does.
- R6: With wr_en_i low, no storage bit changes.
- R7: A read whose bit span overlaps the span being written in the same cycle returns the data stored before that write. The next read of that address returns the new data.
- R8: rd_collide_o is loaded on every read. It is 1 when the read overlapped an active write in that cycle and 0 otherwise.
- R9: While rst_ni is low, rd_data_o and rd_collide_o are 0.
- R10: A write narrower than a wide word changes only its own lane of that word. The other lanes keep their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous active-low reset of the read output registers |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | log2(bits/WR_WIDTH) | Write address at the write aspect ratio |
| wr_data_i | input | WR_WIDTH | Write data |
| rd_en_i | input | 1 | Read enable; the output registers load only when it is high |
| rd_addr_i | input | log2(bits/RD_WIDTH) | Read address at the read aspect ratio |
| rd_data_o | output | RD_WIDTH | Registered read data |
| rd_collide_o | output | 1 | Registered flag: the last read overlapped a same-cycle write |

## Verification
The bound checker checks the following on every cycle:
- the output and flag hold while read enable is low;
- the flag is cleared by any read made without a write;
- the flag rises only after a cycle in which both enables were high.

Data correctness can only be shown by the bench's scenarios. These cover the lane packing order, the old-data result and the following new-data result at a collision, lane isolation for narrow writes, and the last address of each port. They are compared against a bit-level model of the array, run for both the default configuration and a parity-width configuration.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  function automatic bit mw_is_parity(input int w);
    return (w == 9) || (w == 18);
  endfunction

  // R3: supported aspect-ratio pairs
  function automatic bit mw_pair_ok(input int ww, input int rw);
    if (mw_is_parity(ww) || mw_is_parity(rw))
      return mw_is_parity(ww) && mw_is_parity(rw);
    return (ww == 16) &&
           (rw == 1 || rw == 2 || rw == 4 || rw == 8 || rw == 16);
  endfunction

  function automatic int mw_total_bits(input int w);
    return mw_is_parity(w) ? 9216 : 8192;
  endfunction

  function automatic int mw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int mw_lane_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/mwram_addr_map.sv
// Splits a port address into a wide-word row and a narrow lane index.
module mwram_addr_map #(
  parameter int AW     = 11,
  parameter int ROW_AW = 9,
  parameter int LANE_W = 2,
  parameter int RATIO  = 4
) (
  input  logic [AW-1:0]     addr_i,
  output logic [ROW_AW-1:0] row_o,
  output logic [LANE_W-1:0] lane_o
);

  generate
    if (RATIO > 1) begin : g_split
      // R2: low bits pick the lane, high bits pick the wide word
      assign row_o  = addr_i[AW-1 -: ROW_AW];
      assign lane_o = addr_i[LANE_W-1:0];
    end else begin : g_whole
      assign row_o  = addr_i;
      assign lane_o = '0;
    end
  endgenerate

endmodule

// File: rtl/mwram_array.sv
// Storage as wide words; lane-granular write, registered whole-row read.
module mwram_array #(
  parameter int ROWS   = 512,
  parameter int ROW_AW = 9,
  parameter int WIDE_W = 16,
  parameter int WR_W   = 16,
  parameter int WL_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ROW_AW-1:0] wr_row_i,
  input  logic [WL_W-1:0]   wr_lane_i,
  input  logic [WR_W-1:0]   wr_data_i,
  input  logic              rd_en_i,
  input  logic [ROW_AW-1:0] rd_row_i,
  output logic [WIDE_W-1:0] rd_word_o
);

  logic [WIDE_W-1:0] mem_q [ROWS];
  logic [WIDE_W-1:0] rd_word_d, rd_word_q;

  // R6/R10: only the addressed lane of the addressed row is written
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_row_i][int'(wr_lane_i)*WR_W +: WR_W] <= wr_data_i;
    end
  end

  // R7: the row is sampled before the same-edge write lands (old data)
  always_comb begin
    rd_word_d = rd_word_q;
    if (rd_en_i) begin
      rd_word_d = mem_q[rd_row_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_word_q <= '0;
    end else begin
      rd_word_q <= rd_word_d;
    end
  end

  assign rd_word_o = rd_word_q;

endmodule

// File: rtl/mwram_collide.sv
// One port always spans a full wide row, so overlap reduces to row equality.
module mwram_collide #(
  parameter int ROW_AW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ROW_AW-1:0] wr_row_i,
  input  logic [ROW_AW-1:0] rd_row_i,
  output logic              collide_o
);

  logic collide_d, collide_q;

  // R8: reloaded on every read, held otherwise
  always_comb begin
    collide_d = collide_q;
    if (rd_en_i) begin
      collide_d = wr_en_i && (wr_row_i == rd_row_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      collide_q <= 1'b0;
    end else begin
      collide_q <= collide_d;
    end
  end

  assign collide_o = collide_q;

endmodule

// File: rtl/mwram_sdp.sv
module mwram_sdp
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH = 16,
  parameter int RD_WIDTH = 4,
  localparam int TOTAL_BITS = mw_total_bits(WR_WIDTH),
  localparam int WR_AW      = $clog2(TOTAL_BITS / WR_WIDTH),
  localparam int RD_AW      = $clog2(TOTAL_BITS / RD_WIDTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [WR_AW-1:0]    wr_addr_i,
  input  logic [WR_WIDTH-1:0] wr_data_i,
  input  logic                rd_en_i,
  input  logic [RD_AW-1:0]    rd_addr_i,
  output logic [RD_WIDTH-1:0] rd_data_o,
  output logic                rd_collide_o
);

  localparam int WIDE_W   = mw_max(WR_WIDTH, RD_WIDTH);
  localparam int ROWS     = TOTAL_BITS / WIDE_W;
  localparam int ROW_AW   = $clog2(ROWS);
  localparam int WR_RATIO = WIDE_W / WR_WIDTH;
  localparam int RD_RATIO = WIDE_W / RD_WIDTH;
  localparam int WL_W     = mw_lane_bits(WR_RATIO);
  localparam int RL_W     = mw_lane_bits(RD_RATIO);

  // R3: reject unsupported aspect-ratio pairs while elaborating
  generate
    if (!mw_pair_ok(WR_WIDTH, RD_WIDTH)) begin : g_bad_pair
      $error("mwram_sdp: unsupported width pair");
    end
  endgenerate

  logic [ROW_AW-1:0] wr_row, rd_row;
  logic [WL_W-1:0]   wr_lane;
  logic [RL_W-1:0]   rd_lane, rd_lane_d, rd_lane_q;
  logic [WIDE_W-1:0] rd_word;

  mwram_addr_map #(
    .AW(WR_AW), .ROW_AW(ROW_AW), .LANE_W(WL_W), .RATIO(WR_RATIO)
  ) u_wr_map (
    .addr_i(wr_addr_i), .row_o(wr_row), .lane_o(wr_lane)
  );

  mwram_addr_map #(
    .AW(RD_AW), .ROW_AW(ROW_AW), .LANE_W(RL_W), .RATIO(RD_RATIO)
  ) u_rd_map (
    .addr_i(rd_addr_i), .row_o(rd_row), .lane_o(rd_lane)
  );

  mwram_array #(
    .ROWS(ROWS), .ROW_AW(ROW_AW), .WIDE_W(WIDE_W), .WR_W(WR_WIDTH), .WL_W(WL_W)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_row_i(wr_row), .wr_lane_i(wr_lane),
    .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_row_i(rd_row), .rd_word_o(rd_word)
  );

  mwram_collide #(
    .ROW_AW(ROW_AW)
  ) u_collide (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wr_row_i(wr_row), .rd_row_i(rd_row),
    .collide_o(rd_collide_o)
  );

  // Lane pointer travels with the registered row (R4/R5)
  always_comb begin
    rd_lane_d = rd_lane_q;
    if (rd_en_i) begin
      rd_lane_d = rd_lane;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lane_q <= '0;
    end else begin
      rd_lane_q <= rd_lane_d;
    end
  end

  assign rd_data_o = rd_word[int'(rd_lane_q)*RD_WIDTH +: RD_WIDTH];

endmodule

// File: rtl/mwram_sdp_chk.sv
module mwram_sdp_chk #(
  parameter int RD_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [RD_W-1:0] rd_data_o,
  input logic            rd_collide_o
);

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_collide_o)); // R5

  AST_FLAG_CLEAR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> !rd_collide_o); // R8

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_collide_o) |-> $past(rd_en_i && wr_en_i)); // R8

endmodule

bind mwram_sdp mwram_sdp_chk #(.RD_W(RD_WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .rd_collide_o(rd_collide_o)
);

// File: tb/mwram_sdp_tb_top.sv
`timescale 1ns/1ps
module mwram_sdp_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  // default configuration: write 512x16, read 2048x4
  logic        m_we, m_re, m_col;
  logic [8:0]  m_wa;
  logic [15:0] m_wd;
  logic [10:0] m_ra;
  logic [3:0]  m_rd;
  // parity configuration: write 1024x9, read 512x18
  logic        p_we, p_re, p_col;
  logic [9:0]  p_wa;
  logic [8:0]  p_wd;
  logic [8:0]  p_ra;
  logic [17:0] p_rd;

  mwram_sdp #(.WR_WIDTH(16), .RD_WIDTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(m_we), .wr_addr_i(m_wa),
    .wr_data_i(m_wd), .rd_en_i(m_re), .rd_addr_i(m_ra),
    .rd_data_o(m_rd), .rd_collide_o(m_col)
  );

  mwram_sdp #(.WR_WIDTH(9), .RD_WIDTH(18)) dut_par_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(p_we), .wr_addr_i(p_wa),
    .wr_data_i(p_wd), .rd_en_i(p_re), .rd_addr_i(p_ra),
    .rd_data_o(p_rd), .rd_collide_o(p_col)
  );

  bit [8191:0] mm;
  bit [9215:0] mp;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0]  m_exp = '0;
  logic        m_exp_col = 1'b0;
  logic [17:0] p_exp = '0;
  logic        p_exp_col = 1'b0;

  function automatic bit spans_overlap(int wa, int ww, int ra, int rw);
    return (wa*ww < ra*rw + rw) && (ra*rw < wa*ww + ww);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_step(input logic we, input int wa, input logic [15:0] wd,
                        input logic re, input int ra, input string tag);
    m_we = we; m_wa = 9'(wa); m_wd = wd; m_re = re; m_ra = 11'(ra);
    if (re) begin
      m_exp     = mm[ra*4 +: 4];
      m_exp_col = we && spans_overlap(wa, 16, ra, 4);
    end
    @(posedge clk);
    if (we) mm[wa*16 +: 16] = wd;
    @(negedge clk);
    m_we = 1'b0; m_re = 1'b0;
    check({tag, " data"}, 32'(m_rd), 32'(m_exp));
    check({tag, " flag"}, 32'(m_col), 32'(m_exp_col));
  endtask

  task automatic p_step(input logic we, input int wa, input logic [8:0] wd,
                        input logic re, input int ra, input string tag);
    p_we = we; p_wa = 10'(wa); p_wd = wd; p_re = re; p_ra = 9'(ra);
    if (re) begin
      p_exp     = mp[ra*18 +: 18];
      p_exp_col = we && spans_overlap(wa, 9, ra, 18);
    end
    @(posedge clk);
    if (we) mp[wa*9 +: 9] = wd;
    @(negedge clk);
    p_we = 1'b0; p_re = 1'b0;
    check({tag, " data"}, 32'(p_rd), 32'(p_exp));
    check({tag, " flag"}, 32'(p_col), 32'(p_exp_col));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20250);
    rst_n = 1'b0;
    m_we = 0; m_re = 0; m_wa = '0; m_wd = '0; m_ra = '0;
    p_we = 0; p_re = 0; p_wa = '0; p_wd = '0; p_ra = '0;
    repeat (3) @(negedge clk);
    check("R9 reset data", 32'(m_rd), 32'h0);
    check("R9 reset flag", 32'(m_col), 32'h0);
    check("R9 reset parity data", 32'(p_rd), 32'h0);
    check("R9 reset parity flag", 32'(p_col), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill while read idle: output must stay at its reset value
    for (int i = 0; i < 512; i++) m_step(1, i, 16'($urandom), 0, 0, "R5 hold during fill");

    // packing order, checked against constants as well
    m_step(1, 5, 16'hA3C1, 0, 0, "R6 setup");
    m_step(0, 0, 16'h0, 1, 20, "R2 lane0");
    check("R2 lane0 const", 32'(m_rd), 32'h1);
    m_step(0, 0, 16'h0, 1, 21, "R2 lane1");
    check("R2 lane1 const", 32'(m_rd), 32'hC);
    m_step(0, 0, 16'h0, 1, 23, "R2 lane3");
    check("R2 lane3 const", 32'(m_rd), 32'hA);
    m_step(1, 6, 16'h1234, 0, 0, "R5 hold while writing");

    // last addresses of both ports
    m_step(1, 511, 16'h9F5E, 0, 0, "R1 last write");
    m_step(0, 0, 16'h0, 1, 2047, "R1 last read");
    check("R1 last read const", 32'(m_rd), 32'h9);
    m_step(0, 0, 16'h0, 1, 2044, "R1 last row lane0");

    // disabled write leaves storage untouched
    m_step(0, 7, 16'hFFFF, 0, 0, "R6 disabled write");
    for (int i = 28; i < 32; i++) m_step(0, 0, 16'h0, 1, i, "R6 readback");

    // collision: old data then new data
    m_step(1, 9, 16'h5AA5, 1, 37, "R7 R8 collision old data");
    m_step(0, 0, 16'h0, 1, 37, "R7 new data after collision");
    check("R7 new data const", 32'(m_rd), 32'hA);
    m_step(1, 9, 16'h0F0F, 1, 40, "R8 no overlap");
    m_step(1, 10, 16'hBEEF, 1, 40, "R8 overlap");
    m_step(0, 0, 16'h0, 0, 0, "R5 flag held");

    for (int n = 0; n < 600; n++) begin
      int wa, ra;
      wa = int'($urandom % 512);
      ra = ($urandom % 3 == 0) ? wa*4 + int'($urandom % 4) : int'($urandom % 2048);
      m_step(logic'($urandom % 2), wa, 16'($urandom), logic'($urandom % 4 != 0), ra,
             "R1/R2/R4/R7/R8 random");
    end

    // parity pair: narrow writes, wide reads
    for (int i = 0; i < 1024; i++) p_step(1, i, 9'($urandom), 0, 0, "R5 parity fill");
    for (int i = 0; i < 512; i++) p_step(0, 0, 9'h0, 1, i, "R3 parity wide read");
    p_step(1, 21, 9'h1C3, 1, 10, "R7 R8 parity collision");
    p_step(0, 0, 9'h0, 1, 10, "R10 lane isolation");
    check("R10 upper lane const", 32'(p_rd[17:9]), 32'h1C3);
    for (int n = 0; n < 300; n++) begin
      int wa, ra;
      wa = int'($urandom % 1024);
      ra = ($urandom % 3 == 0) ? wa / 2 : int'($urandom % 512);
      p_step(logic'($urandom % 2), wa, 9'($urandom), logic'($urandom % 4 != 0), ra,
             "R3/R10 parity random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule